// File: doc/BRIEF.md
# Periodic Tick Interrupt Register

This block is a periodic interrupt source for a processor subsystem. A free-running divider turns the system clock into ticks at a chosen rate, 60 per second by default. Each tick marks the block as having fired and, if software has enabled interrupts, raises a level-sensitive interrupt request. The request stays up until software acknowledges it.

Software sees one control/status register through a small byte-addressed bus port. The register holds two bits, a "fired" flag and an interrupt-enable. Software acknowledges a tick by writing the fired flag to 0. Software can never set that flag itself. Writing the enable to 1 never raises a request by itself, even when the flag is already set. The request only comes up on the next tick.

Top module: `tick_irq_timer`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, the fired flag is 1, the enable is 0 and `irq_o` is 0. Reset also restarts the divider, so the first tick comes TICK_CYCLES cycles after reset is released.
- R2: A read (`bus_sel`=1, `bus_we`=0) puts the register on `bus_rdata` on the following cycle. The fired flag is at bit 7, the enable is at bit 6, and every other bit is 0. `bus_rdata` is all zeros in any cycle that follows a non-read.
- R3: A write with `bus_addr_lsb`=1 (odd byte) changes neither the fired flag, nor the enable, nor `irq_o`.
- R4: A write with `bus_addr_lsb`=0 loads the enable from `bus_wdata[6]`. It clears the fired flag when `bus_wdata[7]` is 0 and leaves the flag unchanged when that bit is 1, so a write never sets the flag.
- R5: After an even-byte write, `irq_o` is 0 unless both the enable and the fired flag are 1. A write never takes `irq_o` from 0 to 1.
- R6: On each tick the fired flag becomes 1, and `irq_o` becomes 1 if the enable (after any write in the same cycle) is 1.
- R7: Ticks recur exactly every TICK_CYCLES = CLK_HZ / TICK_HZ clock cycles, whatever the bus traffic.
- R8: When a tick and an even-byte write that clears the fired flag fall in the same cycle, the flag ends up 1.
- R9: `irq_o` is 1 only while both the enable and the fired flag are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr_lsb | input | 1 | Byte address bit 0; 1 selects the odd (ignored) byte on writes |
| bus_wdata | input | DATA_W | Write data; bit 7 = fired flag, bit 6 = enable |
| bus_rdata | output | DATA_W | Registered read data |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench builds the block with CLK_HZ=600 and TICK_HZ=60, which gives a 10-cycle tick period. With that period many ticks fit into a short run. It also lets the bench line up a write with the exact cycle of a tick, which covers the tick-versus-clear priority and the case of enable being written while the flag is already set. The default 100 MHz / 60 Hz setting is used only for elaboration, because its period of over a million cycles would hide these cases.

// File: rtl/tick_irq_pkg.sv
package tick_irq_pkg;
  // Register bit positions seen by software.
  parameter int unsigned FIRED_POS = 7;
  parameter int unsigned EN_POS    = 6;

  typedef struct packed {
    logic fired;
    logic en;
  } tick_csr_t;
endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int unsigned CYCLES = 1666666
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tick_ctl_reg.sv
module tick_ctl_reg
  import tick_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      tick_i,
  input  logic      wr_i,
  input  logic      wr_fired_i,
  input  logic      wr_en_i,
  output tick_csr_t csr_o,
  output logic      irq_o
);
  tick_csr_t csr_q, csr_n;
  logic      irq_q, irq_n;

  always_comb begin
    csr_n = csr_q;
    irq_n = irq_q;
    if (wr_i) csr_n.en = wr_en_i;
    if (tick_i)                   csr_n.fired = 1'b1;
    else if (wr_i && !wr_fired_i) csr_n.fired = 1'b0;
    if (tick_i && csr_n.en)                    irq_n = 1'b1;
    else if (wr_i && !(csr_n.en && csr_n.fired)) irq_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_q.fired <= 1'b1;
      csr_q.en    <= 1'b0;
      irq_q       <= 1'b0;
    end else begin
      csr_q <= csr_n;
      irq_q <= irq_n;
    end
  end

  assign csr_o = csr_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/tick_rd_port.sv
module tick_rd_port
  import tick_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_i,
  input  tick_csr_t         csr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] rdata_q, view;

  always_comb begin
    view = '0;
    view[FIRED_POS] = csr_i.fired;
    view[EN_POS]    = csr_i.en;
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_q <= '0;
    else if (rd_i) rdata_q <= view;
    else           rdata_q <= '0;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/tick_irq_timer.sv
module tick_irq_timer
  import tick_irq_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned CLK_HZ  = 100000000,
  parameter int unsigned TICK_HZ = 60
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic              bus_addr_lsb,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  localparam int unsigned TICK_CYCLES = CLK_HZ / TICK_HZ;

  logic      tick;
  logic      wr_even;
  logic      rd_any;
  tick_csr_t csr_q;
  logic      fired_q, en_q;
  logic      unused_wbits;

  assign wr_even      = bus_sel && bus_we && !bus_addr_lsb;
  assign rd_any       = bus_sel && !bus_we;
  assign fired_q      = csr_q.fired;
  assign en_q         = csr_q.en;
  assign unused_wbits = ^bus_wdata;

  tick_divider #(.CYCLES(TICK_CYCLES)) div_i (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  tick_ctl_reg ctl_i (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick),
    .wr_i       (wr_even),
    .wr_fired_i (bus_wdata[FIRED_POS]),
    .wr_en_i    (bus_wdata[EN_POS]),
    .csr_o      (csr_q),
    .irq_o      (irq_o)
  );

  tick_rd_port #(.DATA_W(DATA_W)) rd_i (
    .clk     (clk),
    .rst     (rst),
    .rd_i    (rd_any),
    .csr_i   (csr_q),
    .rdata_o (bus_rdata)
  );
endmodule

// File: rtl/tick_irq_timer_chk.sv
module tick_irq_timer_chk #(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned TICK_CYCLES = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_we,
  input logic              bus_addr_lsb,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              irq_o,
  input logic              tick,
  input logic              fired_q,
  input logic              en_q
);
  logic we_ev, we_odd;
  assign we_ev  = bus_sel && bus_we && !bus_addr_lsb;
  assign we_odd = bus_sel && bus_we && bus_addr_lsb;

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (fired_q && !en_q && !irq_o)); // R1

  AST_ODD_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (we_odd && !tick) |=> ($stable(fired_q) && $stable(en_q) && $stable(irq_o))); // R3

  AST_WRITE_LOADS_EN: assert property (@(posedge clk) disable iff (rst)
    we_ev |=> (en_q == $past(bus_wdata[6]))); // R4

  AST_WRITE_NEVER_SETS_FIRED: assert property (@(posedge clk) disable iff (rst)
    (we_ev && !tick && !fired_q) |=> !fired_q); // R4

  AST_WRITE_NEVER_RAISES: assert property (@(posedge clk) disable iff (rst)
    (we_ev && !tick && !irq_o) |=> !irq_o); // R5

  AST_TICK_SETS_FIRED: assert property (@(posedge clk) disable iff (rst)
    tick |=> fired_q); // R8

  AST_TICK_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
    (tick && en_q && !we_ev) |=> irq_o); // R6

  AST_TICK_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (TICK_CYCLES > 1 && tick) |=> !tick); // R7

  AST_IRQ_NEEDS_BOTH: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (en_q && fired_q)); // R9
endmodule

bind tick_irq_timer tick_irq_timer_chk #(
  .DATA_W(DATA_W),
  .TICK_CYCLES(TICK_CYCLES)
) chk_i (
  .clk          (clk),
  .rst          (rst),
  .bus_sel      (bus_sel),
  .bus_we       (bus_we),
  .bus_addr_lsb (bus_addr_lsb),
  .bus_wdata    (bus_wdata),
  .irq_o        (irq_o),
  .tick         (tick),
  .fired_q      (fired_q),
  .en_q         (en_q)
);

// File: tb/tick_irq_timer_tb.sv
module tick_irq_timer_tb_top;
  localparam int P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic        bus_addr_lsb = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq_o;

  int errors = 0;
  int checks = 0;

  int          m_cnt;
  bit          m_fired, m_en, m_irq;
  logic [15:0] m_rdata;

  always #5 clk = ~clk;

  tick_irq_timer #(.DATA_W(16), .CLK_HZ(600), .TICK_HZ(60)) dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr_lsb(bus_addr_lsb), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic compare(input string tag);
    checks++;
    if (irq_o !== m_irq) begin
      errors++;
      $display("FAIL %s irq_o act=%b exp=%b t=%0t", tag, irq_o, m_irq, $time);
    end
    checks++;
    if (bus_rdata !== m_rdata) begin
      errors++;
      $display("FAIL %s bus_rdata act=%h exp=%h t=%0t", tag, bus_rdata, m_rdata, $time);
    end
  endtask

  task automatic do_reset(input string tag);
    rst = 1'b1; bus_sel = 1'b0; bus_we = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    m_cnt = 0; m_fired = 1; m_en = 0; m_irq = 0; m_rdata = '0;
    compare(tag);
    rst = 1'b0;
  endtask

  task automatic cyc(input bit sel, input bit we, input bit lsb,
                     input logic [15:0] wd, input string tag);
    bit tk, wre, n_fired, n_en, n_irq;
    bus_sel = sel; bus_we = we; bus_addr_lsb = lsb; bus_wdata = wd;
    tk  = (m_cnt == P - 1);
    wre = sel && we && !lsb;
    m_rdata = (sel && !we) ? {8'h00, m_fired, m_en, 6'h00} : 16'h0000;
    n_en    = wre ? wd[6] : m_en;
    n_fired = tk ? 1'b1 : ((wre && !wd[7]) ? 1'b0 : m_fired);
    n_irq   = m_irq;
    if (tk && n_en) n_irq = 1'b1;
    else if (wre && !(n_en && n_fired)) n_irq = 1'b0;
    m_en = n_en; m_fired = n_fired; m_irq = n_irq;
    m_cnt = tk ? 0 : m_cnt + 1;
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 16'h0000, tag);
  endtask

  task automatic rd(input string tag);
    cyc(1, 0, 0, 16'h0000, tag);
    cyc(0, 0, 0, 16'h0000, tag);
  endtask

  task automatic wr(input bit lsb, input logic [15:0] d, input string tag);
    cyc(1, 1, lsb, d, tag);
  endtask

  task automatic align_before_tick(input string tag);
    while (m_cnt != P - 1) cyc(0, 0, 0, 16'h0000, tag);
  endtask

  initial begin
    do_reset("R1");
    rd("R2");                          // expect 0x0080 after reset
    idle(P - 3, "R1");                 // first tick lands at cycle P
    idle(8, "R7");
    rd("R2");
    wr(0, 16'h0000, "R4");             // clear fired, enable off
    rd("R4");
    wr(1, 16'h00C0, "R3");             // odd byte: no effect
    rd("R3");
    wr(0, 16'h0040, "R4");             // enable on, fired stays 0
    rd("R4");
    idle(2 * P + 3, "R6");             // ticks raise irq
    rd("R9");
    wr(0, 16'hFFFF, "R5");             // keep fired, irq remains
    wr(0, 16'h0040, "R5");             // acknowledge, irq drops
    rd("R4");
    wr(0, 16'h00C0, "R4");             // writing 1 does not set fired
    rd("R4");
    wr(0, 16'h0000, "R5");             // disable
    idle(P + 2, "R6");                 // tick sets fired, no irq
    wr(0, 16'h00C0, "R5");             // enable with fired set: no raise
    idle(3, "R5");
    rd("R2");
    idle(P, "R6");
    wr(1, 16'h0000, "R3");             // odd write during irq
    rd("R3");
    align_before_tick("R7");
    wr(0, 16'h0040, "R8");             // clear collides with tick
    rd("R8");
    align_before_tick("R7");
    wr(0, 16'h0000, "R8");             // clear and disable on tick
    rd("R8");
    wr(0, 16'h0040, "R4");
    idle(P, "R6");
    wr(0, 16'h0000, "R5");             // disabling drops irq
    rd("R9");
    idle(4, "R7");
    do_reset("R1");                    // reset mid-period restarts divider
    wr(0, 16'h0040, "R1");
    idle(P + 2, "R7");
    rd("R2");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule